// File: doc/BRIEF.md
# Asynchronous Static RAM Cycle Controller

This block sits between a synchronous system bus and one asynchronous 128K x 8 static RAM. A request carries a 17-bit address, a write flag and 8-bit write data, and is taken with a valid/ready handshake. The controller turns it into a memory cycle whose phases last a whole number of clocks. It drives the memory's active-low and active-high chip selects, its write strobe and output enable, and a tri-state data bus. The bus is split into separate out, out-enable and in signals. Reads return the captured byte with a single-cycle valid strobe. Writes give no response.

The phase lengths are parameters. They are computed from the clock period and the memory's nanosecond limits, each rounded up to whole cycles with a floor of one. The limits are access time, write-strobe width, address-to-write-end time, data setup and output release time. A state machine with six states sequences every cycle. ST_IDLE is the only state that takes a request. ST_IDLE goes to ST_RD_ACCESS on an accepted read and to ST_WR_SETUP on an accepted write. ST_RD_ACCESS goes to ST_RD_RELEASE when its wait count expires, and ST_RD_RELEASE returns to ST_IDLE when the release count expires. ST_WR_SETUP goes to ST_WR_PULSE after one cycle. ST_WR_PULSE goes to ST_WR_HOLD when the strobe count expires, and ST_WR_HOLD returns to ST_IDLE after one cycle. All memory pins are registers that change on the same edge as the state.

Top module: `sram_async_ctrl`

## Requirements
- R1: During and after reset, until the first request: chip select low-active output high, chip select high-active output low, write strobe high, output enable high, data drivers off, `rsp_valid` low, `req_ready` high.
- R2: Whenever the controller is idle (`req_ready` high), the memory is deselected (`sram_cs_n`=1, `sram_cs`=0).
- R3: A read holds `sram_cs_n`=0, `sram_cs`=1, `sram_we_n`=1, `sram_oe_n`=0 and a stable address for exactly RD_CYC consecutive cycles. RD_CYC is the larger of the access-time and cycle-time limits, each divided by the clock period and rounded up.
- R4: The byte on `sram_dq_in` in the last read wait cycle is returned on `rsp_rdata`, with `rsp_valid` high for exactly one cycle, once per read.
- R5: A write holds `sram_we_n` low for exactly WP_CYC consecutive cycles, with both selects active and `sram_oe_n` high. WP_CYC is the strobe width divided by the clock period, rounded up.
- R6: A write drives the data bus with the request's byte and a stable address from one cycle before the strobe falls until one cycle after it rises. Data and address do not change while the strobe is low.
- R7: The data drivers are never on while `sram_oe_n` is low, so the controller and the memory never drive the bus together.
- R8: After a read, the drivers stay off for at least TURN_CYC+2 clock edges after `sram_oe_n` rises. TURN_CYC is the release time divided by the clock period, rounded up.
- R9: A request is taken only when `req_valid` and `req_ready` are both high. `req_ready` is low throughout a memory cycle, and a request presented then is ignored: it writes nothing to memory.
- R10: Requests complete in order, with no loss, at address 0, address 0x1FFFF and any address between. A read returns the byte most recently written there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request taken this edge |
| req_addr | input | 17 | Byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | Read byte valid, one cycle |
| rsp_rdata | output | 8 | Read byte |
| sram_addr | output | 17 | Memory address |
| sram_cs_n | output | 1 | Active-low chip select |
| sram_cs | output | 1 | Active-high chip select |
| sram_we_n | output | 1 | Active-low write strobe |
| sram_oe_n | output | 1 | Active-low output enable |
| sram_dq_out | output | 8 | Data driven toward memory |
| sram_dq_oe | output | 1 | Data driver enable |
| sram_dq_in | input | 8 | Data read from the bus |

## Verification
The bench keeps the 8 ns clock period but gives the controller the limits of a slower memory grade: 20 ns access, 15 ns write strobe and 9 ns release. This yields RD_CYC=3, WP_CYC=2 and TURN_CYC=2. Every timed phase therefore spans several cycles, so an off-by-one in any wait counter, or a capture one cycle early, changes the observed pin sequence. The memory model in the bench drives a poison byte until the address and output enable have been steady for three cycles. An early capture therefore returns the wrong byte.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ACCESS,
        ST_RD_RELEASE,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_WR_HOLD
    } sram_state_e;

    // whole cycles covering t_ps, never fewer than one
    function automatic int unsigned span_cycles(input int unsigned t_ps,
                                                input int unsigned clk_ps);
        int unsigned c;
        c = (t_ps + clk_ps - 1) / clk_ps;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_cycle_timer.sv
module sram_cycle_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             last
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val - 1'b1;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign last = (cnt == '0);

    // a loaded count runs down one per cycle and never wraps
    AST_TMR_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && last) |=> last); // R3
    AST_TMR_LOAD_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (load_val != '0)); // R5
endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [DATA_W-1:0] bus_in,
    output logic              rvalid,
    output logic [DATA_W-1:0] rdata
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid <= 1'b0;
            rdata  <= '0;
        end else begin
            rvalid <= capture;
            if (capture) begin
                rdata <= bus_in;
            end
        end
    end

    AST_RSP_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |=> !rvalid); // R4
    AST_RSP_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(rdata)); // R4
endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W           = 17,
    parameter int DATA_W           = 8,
    parameter int CLK_PERIOD_PS    = 8000,
    parameter int T_ACCESS_PS      = 12000,
    parameter int T_OE_ACCESS_PS   = 6000,
    parameter int T_CYCLE_PS       = 12000,
    parameter int T_WE_PULSE_PS    = 8000,
    parameter int T_ADDR_TO_END_PS = 10000,
    parameter int T_DATA_SETUP_PS  = 7000,
    parameter int T_RELEASE_PS     = 5000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] sram_addr,
    output logic              sram_cs_n,
    output logic              sram_cs,
    output logic              sram_we_n,
    output logic              sram_oe_n,
    output logic [DATA_W-1:0] sram_dq_out,
    output logic              sram_dq_oe,
    input  logic [DATA_W-1:0] sram_dq_in
);
    // phase lengths in cycles
    localparam int RD_CYC   = int'(max2(max2(span_cycles(T_ACCESS_PS, CLK_PERIOD_PS),
                                              span_cycles(T_OE_ACCESS_PS, CLK_PERIOD_PS)),
                                         span_cycles(T_CYCLE_PS, CLK_PERIOD_PS)));
    // setup cycle adds one to address-to-end and data-to-end windows
    localparam int WP_CYC   = int'(max2(span_cycles(T_WE_PULSE_PS, CLK_PERIOD_PS),
                                   max2(span_cycles(T_ADDR_TO_END_PS, CLK_PERIOD_PS) - 1,
                                        span_cycles(T_DATA_SETUP_PS, CLK_PERIOD_PS) - 1)));
    localparam int TURN_CYC = int'(span_cycles(T_RELEASE_PS, CLK_PERIOD_PS));
    localparam int MAX_CYC  = int'(max2(max2(RD_CYC, WP_CYC), TURN_CYC));
    localparam int CNT_W    = $clog2(MAX_CYC + 1) + 1;

    sram_state_e state_q, state_d;

    logic              tmr_load;
    logic [CNT_W-1:0]  tmr_val;
    logic              tmr_last;
    logic              cap_fire;
    logic              accept;

    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;

    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_valid && req_ready;

    sram_cycle_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .last     (tmr_last)
    );

    sram_rd_capture #(.DATA_W(DATA_W)) u_capture (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (cap_fire),
        .bus_in  (sram_dq_in),
        .rvalid  (rsp_valid),
        .rdata   (rsp_rdata)
    );

    // next state and timer loads
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        cap_fire = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    if (req_write) begin
                        state_d = ST_WR_SETUP;
                    end else begin
                        state_d  = ST_RD_ACCESS;
                        tmr_load = 1'b1;
                        tmr_val  = CNT_W'(RD_CYC);
                    end
                end
            end
            ST_RD_ACCESS: begin
                if (tmr_last) begin
                    state_d  = ST_RD_RELEASE;
                    cap_fire = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(TURN_CYC);
                end
            end
            ST_RD_RELEASE: begin
                if (tmr_last) begin
                    state_d = ST_IDLE;
                end
            end
            ST_WR_SETUP: begin
                state_d  = ST_WR_PULSE;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(WP_CYC);
            end
            ST_WR_PULSE: begin
                if (tmr_last) begin
                    state_d = ST_WR_HOLD;
                end
            end
            ST_WR_HOLD: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // state register and request latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            wdata_q <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
        end
    end

    assign sram_addr   = addr_q;
    assign sram_dq_out = wdata_q;

    // registered pin levels, decoded from the next state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sram_cs_n  <= 1'b1;
            sram_cs    <= 1'b0;
            sram_we_n  <= 1'b1;
            sram_oe_n  <= 1'b1;
            sram_dq_oe <= 1'b0;
        end else begin
            sram_cs_n  <= 1'b1;
            sram_cs    <= 1'b0;
            sram_we_n  <= 1'b1;
            sram_oe_n  <= 1'b1;
            sram_dq_oe <= 1'b0;
            unique case (state_d)
                ST_IDLE, ST_RD_RELEASE: begin
                end
                ST_RD_ACCESS: begin
                    sram_cs_n <= 1'b0;
                    sram_cs   <= 1'b1;
                    sram_oe_n <= 1'b0;
                end
                ST_WR_SETUP, ST_WR_HOLD: begin
                    sram_cs_n  <= 1'b0;
                    sram_cs    <= 1'b1;
                    sram_dq_oe <= 1'b1;
                end
                ST_WR_PULSE: begin
                    sram_cs_n  <= 1'b0;
                    sram_cs    <= 1'b1;
                    sram_we_n  <= 1'b0;
                    sram_dq_oe <= 1'b1;
                end
                default: begin
                end
            endcase
        end
    end

    AST_STANDBY_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (sram_cs_n && !sram_cs)); // R2
    AST_STROBE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |-> (!sram_cs_n && sram_cs && sram_oe_n && sram_dq_oe)); // R5
    AST_ADDR_STABLE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_cs_n && $past(!sram_cs_n)) |-> $stable(sram_addr)); // R6
    AST_DATA_STABLE_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (sram_dq_oe && $past(sram_dq_oe)) |-> $stable(sram_dq_out)); // R6
    AST_NO_DRIVE_WITH_OE: assert property (@(posedge clk) disable iff (!rst_n)
        sram_dq_oe |-> sram_oe_n); // R7
    AST_RELEASE_BEFORE_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!sram_oe_n) |-> !sram_dq_oe); // R8
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_cs_n) |-> !req_ready); // R9
endmodule

// File: tb/tb_sram_async_ctrl.sv
`timescale 1ns/1ps
module tb_sram_async_ctrl;
    // slower memory grade on an 8 ns clock: 20/8 -> 3, 15/8 -> 2, 9/8 -> 2
    localparam int EXP_RD   = 3;
    localparam int EXP_WP   = 2;
    localparam int EXP_TURN = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [16:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic [7:0]  req_wdata = '0;
    logic        rsp_valid;
    logic [7:0]  rsp_rdata;
    logic [16:0] sram_addr;
    logic        sram_cs_n, sram_cs, sram_we_n, sram_oe_n, sram_dq_oe;
    logic [7:0]  sram_dq_out;
    logic [7:0]  sram_dq_in = 8'hEE;

    always #4 clk = ~clk;

    sram_async_ctrl #(
        .CLK_PERIOD_PS (8000),
        .T_ACCESS_PS   (20000),
        .T_CYCLE_PS    (20000),
        .T_WE_PULSE_PS (15000),
        .T_RELEASE_PS  (9000)
    ) dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_write(req_write), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .sram_addr(sram_addr), .sram_cs_n(sram_cs_n), .sram_cs(sram_cs),
        .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n),
        .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe), .sram_dq_in(sram_dq_in)
    );

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // memory model: slow access, poison byte until settled
    logic [7:0] mem [int];
    int         rd_age = 0;
    logic [16:0] rd_addr_seen = '0;
    always @(posedge sram_we_n) begin
        if (!sram_cs_n && sram_cs && rst_n) mem[int'(sram_addr)] = sram_dq_out;
    end
    always @(negedge clk) begin
        if (!sram_cs_n && sram_cs && sram_we_n && !sram_oe_n) begin
            if (rd_age > 0 && sram_addr != rd_addr_seen) rd_age = 0;
            rd_age++;
            rd_addr_seen = sram_addr;
        end else begin
            rd_age = 0;
        end
        if (rd_age >= EXP_RD)
            sram_dq_in = mem.exists(int'(sram_addr)) ? mem[int'(sram_addr)] : 8'h00;
        else
            sram_dq_in = 8'hEE;
    end

    // scoreboard
    logic [7:0] shadow [int];
    logic [7:0] exp_q [$];

    task automatic issue(input logic [16:0] a, input bit wr, input logic [7:0] d);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_write = wr; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic do_write(input logic [16:0] a, input logic [7:0] d);
        shadow[int'(a)] = d;
        issue(a, 1'b1, d);
    endtask

    task automatic do_read(input logic [16:0] a);
        exp_q.push_back(shadow.exists(int'(a)) ? shadow[int'(a)] : 8'h00);
        issue(a, 1'b0, 8'h00);
    endtask

    // pin monitors
    int  we_cnt = 0, oe_cnt = 0, gap = 0;
    bit  we_bad = 0, oe_bad = 0, seen_read = 0;
    logic [7:0]  we_data;
    logic [16:0] we_addr, oe_addr;
    logic prev_oe_n = 1'b1, prev_dq_oe = 1'b0, prev_rsp = 1'b0;
    int  contention = 0, standby_bad = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            // R4: scoreboard compare and single pulse
            if (rsp_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R4", "unexpected rsp_valid", 1, 0);
                end else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    check(rsp_rdata == e, "R10", "read data", rsp_rdata, e);
                end
                check(!prev_rsp, "R4", "rsp_valid width", 2, 1);
            end
            // R5/R6 write strobe
            if (!sram_we_n) begin
                if (we_cnt == 0) begin we_data = sram_dq_out; we_addr = sram_addr; end
                we_cnt++;
                if (sram_cs_n || !sram_cs || !sram_oe_n || !sram_dq_oe ||
                    sram_dq_out != we_data || sram_addr != we_addr) we_bad = 1;
            end else if (we_cnt > 0) begin
                check(we_cnt == EXP_WP, "R5", "strobe cycles", we_cnt, EXP_WP);
                check(!we_bad && sram_dq_oe && sram_dq_out == we_data,
                      "R6", "data/addr around strobe", we_bad, 0);
                we_cnt = 0; we_bad = 0;
            end
            // R3 read window
            if (!sram_oe_n) begin
                if (oe_cnt == 0) oe_addr = sram_addr;
                oe_cnt++;
                if (sram_cs_n || !sram_cs || !sram_we_n || sram_addr != oe_addr) oe_bad = 1;
            end else if (oe_cnt > 0) begin
                check(oe_cnt == EXP_RD && !oe_bad, "R3", "read window cycles", oe_cnt, EXP_RD);
                oe_cnt = 0; oe_bad = 0;
            end
            // R8 turnaround
            if (sram_oe_n && !prev_oe_n) begin gap = 1; seen_read = 1; end
            else gap++;
            if (sram_dq_oe && !prev_dq_oe && seen_read) begin
                check(gap >= EXP_TURN + 2, "R8", "edges from oe rise to drive", gap, EXP_TURN + 2);
                seen_read = 0;
            end
            // R7 / R2
            if (sram_dq_oe && !sram_oe_n) contention++;
            if (req_ready && (!sram_cs_n || sram_cs)) standby_bad++;
            prev_oe_n = sram_oe_n; prev_dq_oe = sram_dq_oe; prev_rsp = rsp_valid;
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        check(1'b0, "R1", "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        // R1 reset levels, held in reset
        repeat (3) @(negedge clk);
        check({sram_cs_n, sram_cs, sram_we_n, sram_oe_n, sram_dq_oe, rsp_valid} == 6'b101100,
              "R1", "pins in reset", {sram_cs_n, sram_cs, sram_we_n, sram_oe_n, sram_dq_oe, rsp_valid}, 6'b101100);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check({sram_cs_n, sram_cs, sram_we_n, sram_oe_n, sram_dq_oe, req_ready} == 6'b101101,
              "R1", "pins after reset", {sram_cs_n, sram_cs, sram_we_n, sram_oe_n, sram_dq_oe, req_ready}, 6'b101101);

        // basic write then read
        do_write(17'h00123, 8'h5A);
        do_read(17'h00123);
        // boundary addresses
        do_write(17'h00000, 8'hA5);
        do_write(17'h1FFFF, 8'h3C);
        do_read(17'h1FFFF);
        do_read(17'h00000);
        // read immediately followed by write: R8 turnaround
        do_read(17'h00123);
        do_write(17'h00123, 8'hC3);
        do_read(17'h00123);

        // R9: request presented while busy is ignored
        do_write(17'h00400, 8'h11);
        check(!req_ready, "R9", "ready during write cycle", req_ready, 0);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 17'h00400; req_wdata = 8'hFF;
        @(negedge clk);
        req_valid = 1'b0;
        check(!req_ready, "R9", "ready still low", req_ready, 0);
        do_read(17'h00400);

        // pattern sweep: writes then reads in reverse
        for (int i = 0; i < 16; i++) do_write(17'((i * 7919) & 17'h1FFFF), 8'(i * 37 + 3));
        for (int i = 15; i >= 0; i--) do_read(17'((i * 7919) & 17'h1FFFF));
        // alternating read/write at one address
        for (int i = 0; i < 6; i++) begin
            do_write(17'h0ABCD, 8'(8'h80 ^ i));
            do_read(17'h0ABCD);
        end

        while (!req_ready || exp_q.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R4", "responses outstanding", exp_q.size(), 0);
        check(contention == 0, "R7", "drive while oe low", contention, 0);
        check(standby_bad == 0, "R2", "selected while idle", standby_bad, 0);
        finish_run();
    end
endmodule